// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects a configurable number of level-sensitive peripheral request lines and eight software-driven request flags. It chooses the most urgent pending source and offers it to a single processor as a request line and a 9-bit vector. Each source has its own 4-bit urgency level, which software programs. A level of zero disables the source. The controller keeps a running level for the processor. It forwards a request only when the winning source's level is strictly above that running level.

Nesting works through a small last-in first-out store of running levels. When the processor acknowledges a request, the running level is saved in the store and raised to the level of the source being served. The served vector is also captured so software can read it. A write to the end-of-service register restores the previous running level. Software can also write the running level directly, for example to raise it while it holds a shared resource so that nothing at or below that level can preempt it.

Top module: `pvic_top`

## Requirements
- R1: Each source n has a 4-bit level held in the register at address 0x100+n. A write stores wdata[3:0], and a read returns the stored value zero-extended. All levels are 0 after reset.
- R2: Software sources occupy source numbers 0 to 7. A write to address 1 sets the flags whose wdata[7:0] bits are 1. A write to address 2 clears the flags whose wdata[7:0] bits are 1. A read of address 1 returns the flags in bits 7:0.
- R3: cpu_req is 1 only when some pending source has a nonzero level strictly greater than the running level. A source with level 0 never raises cpu_req.
- R4: cpu_vec carries the source number of the offered request. Peripheral line k is source number 8+k.
- R5: Among eligible sources, the highest level wins. Between equal levels, the lowest source number wins.
- R6: An acknowledge (cpu_ack while cpu_req is 1) saves the running level in the store. It sets the running level to the offered source's level. It captures cpu_vec, which a read of address 3 then returns.
- R7: A write to address 4 (end of service) restores the most recently saved level into the running level. If the store is empty, the running level becomes 0.
- R8: A write to address 0 sets the running level to wdata[3:0]. A read of address 0 returns the running level.
- R9: cpu_req and cpu_vec are registered. They reflect a change on the request lines one clock later. cpu_req is 0 for the cycle following any register write or acknowledge, and is 0 after reset.
- R10: If an end-of-service write and cpu_ack occur in the same cycle, only the end-of-service takes effect, and the captured vector is unchanged.
- R11: The store holds 16 levels, and its occupancy never exceeds that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PERIPH | Level-sensitive peripheral request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 10 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 10 | Register read address |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_vec | output | 9 | Vector of the offered request |
| cpu_ack | input | 1 | Processor acknowledge |

## Verification
A wrong running level shows at the ports within two cycles of the next change on a request line. Either cpu_req rises for a source that should be masked, or it stays low for one that should not. A running level restored in the wrong order shows on the read of address 0 right after the end-of-service write that popped it. A broken tie-break shows on cpu_vec in the cycle after two equal-level sources become pending. The bench compares both outputs after every operation, so an error is reported at the operation that caused it.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRI_W  = 4;
  localparam int NUM_SW = 8;
  localparam int VEC_W  = 9;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CURPRI   = 10'h000;
  localparam logic [ADDR_W-1:0] A_SWSET    = 10'h001;
  localparam logic [ADDR_W-1:0] A_SWCLR    = 10'h002;
  localparam logic [ADDR_W-1:0] A_VEC      = 10'h003;
  localparam logic [ADDR_W-1:0] A_EOI      = 10'h004;
  localparam logic [ADDR_W-1:0] A_PRI_BASE = 10'h100;
endpackage

// File: rtl/pvic_lifo.sv
module pvic_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0] mem [DEPTH];
  logic         full;
  logic         empty;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push && !full) mem[count[$clog2(DEPTH)-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                 count <= '0;
    else if (push && !full)  count <= count + 1'b1;
    else if (pop && !empty)  count <= count - 1'b1;
  end

  logic [CW-1:0] top_idx;
  assign top_idx = count - 1'b1;
  assign dout    = empty ? '0 : mem[top_idx[$clog2(DEPTH)-1:0]];
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb import pvic_pkg::*; #(
  parameter int NS = 16,
  localparam int LG = (NS > 1) ? $clog2(NS) : 1,
  localparam int P  = 1 << LG,
  localparam int NN = 2 * P - 1
) (
  input  logic [NS-1:0]       src_pend,
  input  logic [NS*PRI_W-1:0] pri_flat,
  output logic                win_valid,
  output logic [PRI_W-1:0]    win_pri,
  output logic [VEC_W-1:0]    win_idx
);
  logic             nv [NN];
  logic [PRI_W-1:0] np [NN];
  logic [VEC_W-1:0] ni [NN];

  for (genvar g = 0; g < P; g++) begin : g_leaf
    if (g < NS) begin : g_real
      assign np[P-1+g] = pri_flat[g*PRI_W +: PRI_W];
      assign nv[P-1+g] = src_pend[g] && (pri_flat[g*PRI_W +: PRI_W] != '0);
      assign ni[P-1+g] = VEC_W'(g);
    end else begin : g_pad
      assign np[P-1+g] = '0;
      assign nv[P-1+g] = 1'b0;
      assign ni[P-1+g] = '0;
    end
  end

  for (genvar g = 0; g < P - 1; g++) begin : g_node
    logic take_l;
    assign take_l = nv[2*g+1] && (!nv[2*g+2] || (np[2*g+1] >= np[2*g+2]));
    assign nv[g]  = nv[2*g+1] | nv[2*g+2];
    assign np[g]  = take_l ? np[2*g+1] : np[2*g+2];
    assign ni[g]  = take_l ? ni[2*g+1] : ni[2*g+2];
  end

  assign win_valid = nv[0];
  assign win_pri   = np[0];
  assign win_idx   = ni[0];
endmodule

// File: rtl/pvic_regs.sv
module pvic_regs import pvic_pkg::*; #(
  parameter int NS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   raddr,
  input  logic [PRI_W-1:0]    cur_pri,
  input  logic [VEC_W-1:0]    ack_vec,
  output logic [NS*PRI_W-1:0] pri_flat,
  output logic [NUM_SW-1:0]   sw_flags,
  output logic [DATA_W-1:0]   rdata,
  output logic                curpri_wr,
  output logic                eoi_wr
);
  logic [PRI_W-1:0] pri_q [NS];

  for (genvar g = 0; g < NS; g++) begin : g_pri
    localparam logic [ADDR_W-1:0] MY_ADDR = A_PRI_BASE + ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (rst)                          pri_q[g] <= '0;
      else if (wr && waddr == MY_ADDR)  pri_q[g] <= wdata[PRI_W-1:0];
    end
    assign pri_flat[g*PRI_W +: PRI_W] = pri_q[g];
  end

  logic [NUM_SW-1:0] set_bits;
  logic [NUM_SW-1:0] clr_bits;
  assign set_bits = (wr && waddr == A_SWSET) ? wdata[NUM_SW-1:0] : '0;
  assign clr_bits = (wr && waddr == A_SWCLR) ? wdata[NUM_SW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) sw_flags <= '0;
    else     sw_flags <= (sw_flags | set_bits) & ~clr_bits;
  end

  assign curpri_wr = wr && (waddr == A_CURPRI);
  assign eoi_wr    = wr && (waddr == A_EOI);

  logic [DATA_W-1:0] rmux;
  always_comb begin
    rmux = '0;
    case (raddr)
      A_CURPRI: rmux = DATA_W'(cur_pri);
      A_SWSET:  rmux = DATA_W'(sw_flags);
      A_VEC:    rmux = DATA_W'(ack_vec);
      default: begin
        for (int i = 0; i < NS; i++) begin
          if (raddr == A_PRI_BASE + ADDR_W'(i)) rmux = DATA_W'(pri_q[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top import pvic_pkg::*; #(
  parameter int NUM_PERIPH = 208,
  parameter int LIFO_DEPTH = 16,
  localparam int NS = NUM_SW + NUM_PERIPH,
  localparam int CW = $clog2(LIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PERIPH-1:0] irq_in,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_waddr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_raddr,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  cpu_req,
  output logic [VEC_W-1:0]      cpu_vec,
  input  logic                  cpu_ack
);
  logic [NS*PRI_W-1:0] pri_flat;
  logic [NUM_SW-1:0]   sw_flags;
  logic                curpri_wr;
  logic                eoi_wr;
  logic [PRI_W-1:0]    cur_pri;
  logic [VEC_W-1:0]    ack_vec;
  logic [PRI_W-1:0]    win_pri_q;
  logic                arb_valid;
  logic [PRI_W-1:0]    arb_pri;
  logic [VEC_W-1:0]    arb_idx;
  logic [PRI_W-1:0]    lifo_dout;
  logic [CW-1:0]       lifo_cnt;
  logic                ack_fire;

  pvic_regs #(.NS(NS)) u_regs (
    .clk(clk), .rst(rst),
    .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
    .rd(reg_rd), .raddr(reg_raddr),
    .cur_pri(cur_pri), .ack_vec(ack_vec),
    .pri_flat(pri_flat), .sw_flags(sw_flags), .rdata(reg_rdata),
    .curpri_wr(curpri_wr), .eoi_wr(eoi_wr)
  );

  pvic_arb #(.NS(NS)) u_arb (
    .src_pend({irq_in, sw_flags}),
    .pri_flat(pri_flat),
    .win_valid(arb_valid), .win_pri(arb_pri), .win_idx(arb_idx)
  );

  assign ack_fire = cpu_ack && cpu_req && !eoi_wr;

  pvic_lifo #(.DEPTH(LIFO_DEPTH), .W(PRI_W)) u_lifo (
    .clk(clk), .rst(rst),
    .push(ack_fire), .pop(eoi_wr),
    .din(cur_pri), .dout(lifo_dout), .count(lifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)            cur_pri <= '0;
    else if (eoi_wr)    cur_pri <= lifo_dout;
    else if (ack_fire)  cur_pri <= win_pri_q;
    else if (curpri_wr) cur_pri <= reg_wdata[PRI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           ack_vec <= '0;
    else if (ack_fire) ack_vec <= cpu_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_req   <= 1'b0;
      cpu_vec   <= '0;
      win_pri_q <= '0;
    end else begin
      cpu_req   <= !(reg_wr || ack_fire) && arb_valid && (arb_pri > cur_pri);
      cpu_vec   <= arb_idx;
      win_pri_q <= arb_pri;
    end
  end
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk import pvic_pkg::*; #(
  parameter int NS         = 16,
  parameter int LIFO_DEPTH = 16,
  localparam int CW = $clog2(LIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_req,
  input logic [VEC_W-1:0] cpu_vec,
  input logic             cpu_ack,
  input logic             eoi_wr,
  input logic [PRI_W-1:0] cur_pri,
  input logic [PRI_W-1:0] win_pri_q,
  input logic [VEC_W-1:0] ack_vec,
  input logic [CW-1:0]    lifo_cnt
);
  AST_REQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> (win_pri_q > cur_pri)); // R3
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> (int'(cpu_vec) < NS)); // R4
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_req && !eoi_wr) |=> (cur_pri == $past(win_pri_q))); // R6
  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_req && !eoi_wr) |=> (ack_vec == $past(cpu_vec))); // R6
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_req) |=> !cpu_req); // R9
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && lifo_cnt == '0) |=> (cur_pri == '0)); // R7
  AST_EOI_WINS: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && cpu_ack) |=> $stable(ack_vec)); // R10
  AST_LIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    lifo_cnt <= CW'(LIFO_DEPTH)); // R11
endmodule

bind pvic_top pvic_chk #(.NS(NS), .LIFO_DEPTH(LIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_vec(cpu_vec),
  .cpu_ack(cpu_ack), .eoi_wr(eoi_wr), .cur_pri(cur_pri),
  .win_pri_q(win_pri_q), .ack_vec(ack_vec), .lifo_cnt(lifo_cnt)
);

// File: tb/sim_pvic_top.sv
module sim_pvic_top;
  localparam int NP = 24;
  localparam int NS = 8 + NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic          reg_wr = 1'b0;
  logic [9:0]    reg_waddr = '0;
  logic [15:0]   reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [9:0]    reg_raddr = '0;
  logic [15:0]   reg_rdata;
  logic          cpu_req;
  logic [8:0]    cpu_vec;
  logic          cpu_ack = 1'b0;

  always #5 clk = ~clk;

  pvic_top #(.NUM_PERIPH(NP), .LIFO_DEPTH(16)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int mpri [NS];
  bit [7:0] msw;
  int mcur;
  int mvec;
  int mstk [16];
  int msp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pend(input int i);
    if (i < 8) return msw[i];
    return irq_in[i-8];
  endfunction

  function automatic int winner();
    int best = -1;
    for (int i = 0; i < NS; i++) begin
      if (pend(i) && mpri[i] > 0 && (best < 0 || mpri[i] > mpri[best])) best = i;
    end
    return best;
  endfunction

  function automatic bit exp_req();
    int w = winner();
    return (w >= 0) && (mpri[w] > mcur);
  endfunction

  task automatic check_out(input string req);
    bit e = exp_req();
    chk(cpu_req == e, {req, " req"}, int'(cpu_req), int'(e));
    if (e && cpu_req) chk(int'(cpu_vec) == winner(), {req, " vec"}, int'(cpu_vec), winner());
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 10'(addr); reg_wdata = 16'(data);
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int addr, output int val);
    @(negedge clk);
    reg_rd = 1'b1; reg_raddr = 10'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
    val = int'(reg_rdata);
  endtask

  task automatic set_pri(input int src, input int p);
    wr(32'h100 + src, p); mpri[src] = p & 15;
  endtask
  task automatic sw_set(input int m);
    wr(1, m); msw = msw | 8'(m);
  endtask
  task automatic sw_clr(input int m);
    wr(2, m); msw = msw & ~8'(m);
  endtask
  task automatic set_cur(input int p);
    wr(0, p); mcur = p & 15;
  endtask
  task automatic set_irq(input logic [NP-1:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask
  task automatic eoi();
    wr(4, 0);
    if (msp > 0) begin msp--; mcur = mstk[msp]; end
    else mcur = 0;
  endtask
  task automatic ack();
    bit e = exp_req();
    int w = winner();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    chk(cpu_req == 1'b0, "R9 quiet after ack", int'(cpu_req), 0);
    @(negedge clk);
    if (e) begin
      if (msp < 16) begin mstk[msp] = mcur; msp++; end
      mcur = mpri[w]; mvec = w;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NS; i++) mpri[i] = 0;
    msw = '0; mcur = 0; mvec = 0; msp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(cpu_req == 1'b0, "R9 reset req", int'(cpu_req), 0);
    rd(0, v);  chk(v == 0, "R8 reset level", v, 0);
    rd(1, v);  chk(v == 0, "R2 reset flags", v, 0);
    rd(3, v);  chk(v == 0, "R6 reset vector", v, 0);
    rd(32'h105, v); chk(v == 0, "R1 reset level entry", v, 0);

    // R1 level registers
    set_pri(5, 9); set_pri(20, 16'hfff3);
    rd(32'h105, v); chk(v == 9, "R1 readback", v, 9);
    rd(32'h114, v); chk(v == 3, "R1 readback masked", v, 3);

    // R3 level 0 never requests
    set_irq(24'h1);
    chk(cpu_req == 1'b0, "R3 level zero", int'(cpu_req), 0);

    // R2 / R4 software source
    sw_set(32'h20);
    rd(1, v); chk(v == 32'h20, "R2 flags", v, 32'h20);
    check_out("R2");
    chk(cpu_vec == 9'd5, "R4 sw vector", int'(cpu_vec), 5);

    // R5 tie: source 8 equal level, lower number 5 wins
    set_pri(8, 9);
    check_out("R5 tie");
    chk(cpu_vec == 9'd5, "R5 tie lowest", int'(cpu_vec), 5);
    sw_clr(32'h20);
    check_out("R5 after clear");
    chk(cpu_vec == 9'd8, "R4 periph vector", int'(cpu_vec), 8);
    set_pri(12, 12); set_irq(24'h11);
    chk(cpu_vec == 9'd12, "R5 highest", int'(cpu_vec), 12);

    // R8 running level
    set_cur(12);
    chk(cpu_req == 1'b0, "R3 equal masked", int'(cpu_req), 0);
    set_cur(11);
    check_out("R8");
    rd(0, v); chk(v == 11, "R8 readback", v, 11);

    // R6 acknowledge and nesting, R7 restore
    ack();
    rd(3, v); chk(v == 12, "R6 vector latch", v, 12);
    rd(0, v); chk(v == 12, "R6 level raised", v, 12);
    check_out("R6");
    set_pri(20, 14); set_irq(24'h1011);
    check_out("R6 nest");
    ack();
    rd(0, v); chk(v == 14, "R6 nested level", v, 14);
    eoi(); rd(0, v); chk(v == 12, "R7 pop", v, 12);
    eoi(); rd(0, v); chk(v == 11, "R7 pop2", v, 11);
    eoi(); rd(0, v); chk(v == 0, "R7 empty", v, 0);
    eoi(); rd(0, v); chk(v == 0, "R7 empty again", v, 0);
    check_out("R7");

    // R10 end-of-service together with acknowledge
    set_cur(3);
    sw_set(32'h2); set_pri(1, 6);
    check_out("R10 setup");
    @(negedge clk);
    cpu_ack = 1'b1; reg_wr = 1'b1; reg_waddr = 10'd4; reg_wdata = '0;
    @(negedge clk);
    cpu_ack = 1'b0; reg_wr = 1'b0;
    mcur = 0;
    rd(0, v); chk(v == 0, "R10 level", v, 0);
    rd(3, v); chk(v == mvec, "R10 vector kept", v, mvec);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 9);
      case (op)
        0, 1: set_pri(int'($urandom % NS), int'($urandom % 16));
        2: sw_set(int'($urandom & $urandom & 8'hff));
        3: sw_clr(int'($urandom & 8'hff));
        4: set_irq(NP'($urandom & $urandom));
        5, 6: ack();
        7: eoi();
        default: set_cur(int'($urandom % 8));
      endcase
      check_out("R5 random");
      if (it % 16 == 0) begin
        rd(0, v); chk(v == mcur, "R11 random level", v, mcur);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule